// File: doc/BRIEF.md
# DRAM Compressed Parallel Test Mode Controller

This block models the device-side control of a one-bit-wide DRAM whose cell array is split internally into eight equal sectors. It watches the three active-low strobes (row strobe, column strobe, write enable) on a synchronous clock and sorts every row-strobe falling edge. The edge is either an ordinary row opening or a column-before-row refresh. From the column-before-row cycles it decides whether the part is in normal mode or in a compressed test mode.

In normal mode each column access reads or writes one bit at the multiplexed row and column address. In test mode, three address bits choose the sector and are ignored: the row MSB, the column MSB and the column LSB. A write stores the input bit into all eight sectors at once, so the part behaves as a memory of one-eighth depth. A read returns 1 when the eight addressed bits all agree and 0 when any of them differs. A tester can therefore check the whole array in one eighth of the accesses. The array is a small parameterised register file.

The controller has six states. ST_IDLE covers precharge, with the row strobe high. ST_ROW_OPEN means a row is latched and no column access has happened yet. ST_COL_ACTIVE means the column strobe is low and an access is in progress. ST_PAGE_GAP means the column strobe is high again after an access, with the row still open. ST_CBR_CHK is the one cycle in which a column-before-row entry is judged. ST_CBR_HOLD waits for the row strobe to rise after a refresh.

The transitions are as follows:
- ST_IDLE goes to ST_ROW_OPEN when the row strobe falls with the column strobe high.
- ST_IDLE goes to ST_CBR_CHK when the row strobe falls with the column strobe low.
- ST_ROW_OPEN and ST_PAGE_GAP go to ST_COL_ACTIVE when the column strobe falls.
- ST_COL_ACTIVE goes to ST_PAGE_GAP when the column strobe rises.
- ST_CBR_CHK goes to ST_CBR_HOLD.
- Every state returns to ST_IDLE when the row strobe is high. The return from ST_ROW_OPEN is a row-only refresh.

Top module: `dram_ptm_top`

## Requirements
- R1: Reset puts the block in normal mode, clears every array bit to 0 and holds dout_oe at 0.
- R2: In normal mode, a column access samples addr as the column when the column strobe is first seen low. Its row is the addr sampled when the row strobe fell. With we_n low, it stores din at index row*2^COL_W+column. With we_n high, it drives the stored bit on dout, and dout_oe is 1 from the clock after the column strobe is sampled low until the clock at which it is sampled high.
- R3: Several column accesses may follow one another within a single open row (page mode), each at its own column.
- R4: A row-strobe fall sampled with cas_n low, with we_n low in the sample before the fall, the sample of the fall and the sample after it, enters test mode.
- R5: If we_n is high in any one of those three samples, the cycle is an ordinary refresh and test mode is not entered.
- R6: Test mode is left by a column-before-row cycle that does not meet R4, or by a row-only cycle, in which the row strobe rises with no column access. Column accesses do not change the mode.
- R7: A test-mode write stores din into all eight sectors. The sector number is {row MSB, column MSB, column LSB}, and the remaining address bits pick the cell within a sector.
- R8: A test-mode read returns 1 on dout if the eight sector bits are all equal and 0 if any differs. The three sector bits of the address have no effect.
- R9: A write with we_n low when the column strobe falls (early write) keeps dout_oe at 0. A fall of we_n during an active read (read-modify-write) stores din while dout and dout_oe keep showing the data read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | max(ROW_W,COL_W) | Multiplexed row/column address |
| din | input | 1 | Write data |
| dout | output | 1 | Read data or test compare flag |
| dout_oe | output | 1 | High while dout is driven |

## Verification
The bench sweeps every address of the default 16x16 array in page mode and fills all 32 compressed locations with broadcast writes. It then reads the whole array back in normal mode. A design that decoded a sector bit at the wrong position would misplace about half of those bits. It plants one flipped bit and checks that the compare flag drops to 0. A design that compared fewer than eight sectors, or that folded the ignored address bits into the compare, would instead return 1 or a stored bit. Entry attempts that break the write-enable window at each of the three sample points must leave the part in normal mode. A design that checked only the fall itself would enter test mode and return the compare flag instead of the stored 1. Plain refresh and row-only cycles must leave test mode. A read-modify-write must hold the read data while storing the new bit, and an early write must keep the output disabled.

// File: rtl/dram_ptm_pkg.sv
package dram_ptm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_ROW_OPEN   = 3'd1,
        ST_COL_ACTIVE = 3'd2,
        ST_PAGE_GAP   = 3'd3,
        ST_CBR_CHK    = 3'd4,
        ST_CBR_HOLD   = 3'd5
    } ptm_state_t;

    localparam int SECTORS = 8;

endpackage

// File: rtl/dram_ptm_array.sv
module dram_ptm_array
    import dram_ptm_pkg::*;
#(
    parameter int ROW_W = 4,
    parameter int COL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             test_mode,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic             wr_en,
    input  logic             wr_bit,
    output logic             rd_bit
);
    localparam int IDX_W = ROW_W + COL_W;
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0]   mem;
    logic [IDX_W-1:0]   sec_idx [SECTORS];
    logic [SECTORS-1:0] sec_bits;

    // checker-side copy of the last broadcast address
    logic               lw_valid;
    logic               lw_bit;
    logic [ROW_W-1:0]   lw_row;
    logic [COL_W-1:0]   lw_col;
    logic [IDX_W-1:0]   chk_idx [SECTORS];
    logic [SECTORS-1:0] chk_bits;

    for (genvar s = 0; s < SECTORS; s++) begin : g_sector
        localparam logic [2:0] SV = 3'(s);
        assign sec_idx[s] = {SV[2], row[ROW_W-2:0], SV[1], col[COL_W-2:1], SV[0]};
        assign sec_bits[s] = mem[sec_idx[s]];
        assign chk_idx[s] = {SV[2], lw_row[ROW_W-2:0], SV[1], lw_col[COL_W-2:1], SV[0]};
        assign chk_bits[s] = mem[chk_idx[s]];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= '0;
        end else if (wr_en) begin
            if (test_mode) begin
                for (int s = 0; s < SECTORS; s++) begin
                    mem[sec_idx[s]] <= wr_bit;
                end
            end else begin
                mem[{row, col}] <= wr_bit;
            end
        end
    end

    always_comb begin
        if (test_mode) begin
            rd_bit = (&sec_bits) | (~|sec_bits);
        end else begin
            rd_bit = mem[{row, col}];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lw_valid <= 1'b0;
            lw_bit   <= 1'b0;
            lw_row   <= '0;
            lw_col   <= '0;
        end else begin
            lw_valid <= wr_en && test_mode;
            lw_bit   <= wr_bit;
            lw_row   <= row;
            lw_col   <= col;
        end
    end

    // R7: after a broadcast write all eight sectors hold the written bit
    a_r7_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
        lw_valid |-> (chk_bits == {SECTORS{lw_bit}}));

endmodule

// File: rtl/dram_ptm_ctrl.sv
module dram_ptm_ctrl
    import dram_ptm_pkg::*;
#(
    parameter int ROW_W = 4,
    parameter int COL_W = 4,
    parameter int AW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic [AW-1:0]    addr,
    input  logic             arr_rd_bit,
    output logic             test_mode,
    output logic [ROW_W-1:0] arr_row,
    output logic [COL_W-1:0] arr_col,
    output logic             arr_wr,
    output logic             dout,
    output logic             dout_oe
);
    ptm_state_t state, state_nx;

    logic             we_q;
    logic             we_ok_q;
    logic             early_q;
    logic             wrote_q;
    logic             rd_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;

    logic col_fall;
    logic late_wr;
    logic cbr_start;
    logic row_start;
    logic ras_only;

    assign col_fall  = (state == ST_ROW_OPEN || state == ST_PAGE_GAP) && !ras_n && !cas_n;
    assign late_wr   = (state == ST_COL_ACTIVE) && !ras_n && !cas_n && we_q && !we_n && !wrote_q;
    assign cbr_start = (state == ST_IDLE) && !ras_n && !cas_n;
    assign row_start = (state == ST_IDLE) && !ras_n && cas_n;
    assign ras_only  = (state == ST_ROW_OPEN) && ras_n;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (!ras_n) state_nx = cas_n ? ST_ROW_OPEN : ST_CBR_CHK;
            end
            ST_ROW_OPEN, ST_PAGE_GAP: begin
                if (ras_n)       state_nx = ST_IDLE;
                else if (!cas_n) state_nx = ST_COL_ACTIVE;
            end
            ST_COL_ACTIVE: begin
                if (ras_n)      state_nx = ST_IDLE;
                else if (cas_n) state_nx = ST_PAGE_GAP;
            end
            ST_CBR_CHK: begin
                state_nx = ras_n ? ST_IDLE : ST_CBR_HOLD;
            end
            ST_CBR_HOLD: begin
                if (ras_n) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register and mode flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            test_mode <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_CBR_CHK) begin
                test_mode <= !we_n && we_ok_q;
            end else if (ras_only) begin
                test_mode <= 1'b0;
            end
        end
    end

    // address and access registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b1;
            we_ok_q <= 1'b0;
            early_q <= 1'b0;
            wrote_q <= 1'b0;
            rd_q    <= 1'b0;
            row_q   <= '0;
            col_q   <= '0;
        end else begin
            we_q <= we_n;
            if (cbr_start) begin
                we_ok_q <= !we_n && !we_q;
            end
            if (row_start) begin
                row_q <= addr[ROW_W-1:0];
            end
            if (col_fall) begin
                col_q   <= addr[COL_W-1:0];
                rd_q    <= arr_rd_bit;
                early_q <= !we_n;
                wrote_q <= !we_n;
            end else if (late_wr) begin
                wrote_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        arr_row = row_q;
        arr_col = col_fall ? addr[COL_W-1:0] : col_q;
        arr_wr  = (col_fall && !we_n) || late_wr;
        dout_oe = (state == ST_COL_ACTIVE) && !early_q;
        dout    = dout_oe ? rd_q : 1'b0;
    end

    // R4: test mode is only ever entered from the entry-judgement state
    a_r4_entry_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_mode) |-> ($past(state) == ST_CBR_CHK));

    // R6: test mode is only left by a refresh decision or a row-only cycle
    a_r6_exit_source: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(test_mode) |-> ($past(state) == ST_CBR_CHK || $past(state) == ST_ROW_OPEN));

    // R2: output only driven after both strobes were sampled low
    a_r2_oe_needs_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> $past(!cas_n && !ras_n));

    // R9: an early write never enables the output
    a_r9_early_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (col_fall && !we_n) |=> !dout_oe);

endmodule

// File: rtl/dram_ptm_top.sv
module dram_ptm_top
    import dram_ptm_pkg::*;
#(
    parameter  int ROW_W = 4,
    parameter  int COL_W = 4,
    localparam int AW    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic          din,
    output logic          dout,
    output logic          dout_oe
);
    logic             test_mode;
    logic [ROW_W-1:0] arr_row;
    logic [COL_W-1:0] arr_col;
    logic             arr_wr;
    logic             arr_rd_bit;

    dram_ptm_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n),
        .addr       (addr),
        .arr_rd_bit (arr_rd_bit),
        .test_mode  (test_mode),
        .arr_row    (arr_row),
        .arr_col    (arr_col),
        .arr_wr     (arr_wr),
        .dout       (dout),
        .dout_oe    (dout_oe)
    );

    dram_ptm_array #(.ROW_W(ROW_W), .COL_W(COL_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_mode (test_mode),
        .row       (arr_row),
        .col       (arr_col),
        .wr_en     (arr_wr),
        .wr_bit    (din),
        .rd_bit    (arr_rd_bit)
    );

endmodule

// File: tb/dram_ptm_top_tb.sv
module dram_ptm_top_tb;
    localparam int RW = 4;
    localparam int CW = 4;
    localparam int AW = 4;
    localparam int N  = 1 << (RW + CW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ras_n = 1'b1;
    logic          cas_n = 1'b1;
    logic          we_n = 1'b1;
    logic          din = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          dout;
    logic          dout_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit mem_m [N];
    bit tmode_m = 1'b0;
    int cur_row = 0;

    always #2 clk = ~clk;

    dram_ptm_top #(.ROW_W(RW), .COL_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
    );

    function automatic int ix(int r, int c);
        return (r << CW) | c;
    endfunction

    function automatic int sec_ix(int s, int r, int c);
        int rr;
        int cc;
        rr = (((s >> 2) & 1) << (RW - 1)) | (r & ((1 << (RW - 1)) - 1));
        cc = (((s >> 1) & 1) << (CW - 1)) | (c & ((1 << (CW - 1)) - 2)) | (s & 1);
        return ix(rr, cc);
    endfunction

    function automatic bit exp_rd(int r, int c);
        int ones;
        if (!tmode_m) return mem_m[ix(r, c)];
        ones = 0;
        for (int s = 0; s < 8; s++) ones += int'(mem_m[sec_ix(s, r, c)]);
        return (ones == 0) || (ones == 8);
    endfunction

    task automatic model_wr(int r, int c, bit b);
        if (tmode_m) begin
            for (int s = 0; s < 8; s++) mem_m[sec_ix(s, r, c)] = b;
        end else begin
            mem_m[ix(r, c)] = b;
        end
    endtask

    task automatic check(logic got, logic exp, string req, string what);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic open_row(int r);
        cur_row = r;
        addr = AW'(r);
        ras_n = 1'b0;
        step(1);
    endtask

    task automatic close_row();
        ras_n = 1'b1;
        step(2);
    endtask

    task automatic cas_rd(int c, string req);
        addr = AW'(c);
        we_n = 1'b1;
        cas_n = 1'b0;
        step(1);
        check(dout_oe, 1'b1, req, $sformatf("read oe r%0d c%0d", cur_row, c));
        check(dout, exp_rd(cur_row, c), req, $sformatf("read data r%0d c%0d", cur_row, c));
        cas_n = 1'b1;
        step(1);
    endtask

    task automatic cas_wr(int c, bit b);
        addr = AW'(c);
        din = b;
        we_n = 1'b0;
        cas_n = 1'b0;
        step(1);
        check(dout_oe, 1'b0, "R9", "early write keeps output off");
        model_wr(cur_row, c, b);
        we_n = 1'b1;
        cas_n = 1'b1;
        step(1);
    endtask

    task automatic single_rd(int r, int c, string req);
        open_row(r);
        cas_rd(c, req);
        close_row();
    endtask

    task automatic cbr(bit wb, bit wa, bit wf);
        cas_n = 1'b0;
        we_n = wb;
        step(1);
        ras_n = 1'b0;
        we_n = wa;
        step(1);
        we_n = wf;
        step(1);
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n = 1'b1;
        step(2);
        tmode_m = !wb && !wa && !wf;
    endtask

    initial begin
        step(3);
        // R1: output disabled in reset
        check(dout_oe, 1'b0, "R1", "oe during reset");
        rst_n = 1'b1;
        step(1);
        // enter test mode, then reset must return to normal mode
        cbr(1'b0, 1'b0, 1'b0);
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
        tmode_m = 1'b0;
        for (int i = 0; i < N; i++) mem_m[i] = 1'b0;
        single_rd(0, 1, "R1");
        open_row(0);
        cas_wr(0, 1'b1);
        close_row();
        single_rd(0, 0, "R1");

        // R2/R3: page-mode sweep of the whole array
        for (int r = 0; r < (1 << RW); r++) begin
            open_row(r);
            for (int c = 0; c < (1 << CW); c++) cas_wr(c, bit'(((r * 5 + c * 3) >> 1) & 1));
            close_row();
        end
        for (int r = 0; r < (1 << RW); r++) begin
            open_row(r);
            for (int c = 0; c < (1 << CW); c++) cas_rd(c, "R3");
            close_row();
        end

        // R9: read-modify-write
        open_row(3);
        addr = AW'(5);
        we_n = 1'b1;
        cas_n = 1'b0;
        step(1);
        check(dout, exp_rd(3, 5), "R9", "rmw read data");
        din = !exp_rd(3, 5);
        we_n = 1'b0;
        step(1);
        check(dout_oe, 1'b1, "R9", "rmw oe held");
        check(dout, exp_rd(3, 5), "R9", "rmw data held");
        model_wr(3, 5, din);
        we_n = 1'b1;
        cas_n = 1'b1;
        step(1);
        close_row();
        single_rd(3, 5, "R9");

        // R4/R7: enter test mode and broadcast
        cbr(1'b0, 1'b0, 1'b0);
        for (int cr = 0; cr < 8; cr++) begin
            open_row(cr);
            for (int cc = 0; cc < 4; cc++) cas_wr(cc << 1, bit'((cr + cc) & 1));
            close_row();
        end
        // R8: reads with sector bits set to varied values
        for (int cr = 0; cr < 8; cr++) begin
            open_row(cr | ((cr & 1) << 3));
            for (int cc = 0; cc < 4; cc++) cas_rd((cc << 1) | ((cc & 1) << 3) | ((cr >> 1) & 1), "R8");
            close_row();
        end

        // R6: row-only cycle leaves test mode; R7: full normal readback
        open_row(0);
        close_row();
        tmode_m = 1'b0;
        for (int r = 0; r < (1 << RW); r++) begin
            open_row(r);
            for (int c = 0; c < (1 << CW); c++) cas_rd(c, "R7");
            close_row();
        end

        // R8: flip one bit and look for a mismatch flag
        open_row(0);
        cas_wr(0, 1'b1);
        close_row();
        cbr(1'b0, 1'b0, 1'b0);
        single_rd(0, 0, "R4");
        single_rd(8, 9, "R8");
        single_rd(1, 2, "R8");

        // R6: plain refresh exits
        cbr(1'b1, 1'b1, 1'b1);
        single_rd(0, 0, "R6");

        // R5: each broken sample of the write-enable window blocks entry
        cbr(1'b1, 1'b0, 1'b0);
        single_rd(0, 0, "R5");
        cbr(1'b0, 1'b1, 1'b0);
        single_rd(0, 0, "R5");
        cbr(1'b0, 1'b0, 1'b1);
        single_rd(0, 0, "R5");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule